// File: doc/BRIEF.md
# Two-wire serial EEPROM target controller

This block is the device side of a byte-wide nonvolatile memory that sits on a two-wire serial bus. A fast system clock samples the bus clock and data lines through two-flop synchronisers. The block detects start and stop conditions and shifts address and data bytes in and out. It acknowledges each byte it accepts by pulling the data line low. The memory array is a register array inside the block. A host writes single bytes or whole pages, reads from the internal address counter, loads that counter with a dummy write before a random read, and streams sequential reads.

A write is collected in a page buffer and stored only when the stop condition ends it. The stop also starts an emulated internally timed write cycle that lasts a set number of system clocks. For that time the block refuses to acknowledge its own address, so the host can poll until the cycle is done. The data output is an open-drain style enable. When it is high, the bus data line is pulled low.

Top module: `eeprom_target`

## Requirements
- R1: A start condition (data falls while clock is high) restarts reception of a device address word from any state, including in the middle of a byte. A stop condition (data rises while clock is high) returns the block to idle.
- R2: The device address word is accepted only if bits 7:4 equal 4'b1010 and bits 3:1 equal the strap inputs. Bit 0 is the direction: 1 means read, 0 means write. A word that does not match gets no acknowledge, and the data line stays released during the ninth clock.
- R3: Each accepted byte is acknowledged by driving data low for the ninth clock pulse. The block changes its data output only while the bus clock is low, and it releases the data line while idle and after reset.
- R4: A byte write is a write address word, one memory address byte (8-bit default array) and one data byte, followed by a stop. It stores that byte at that address.
- R5: A page write accepts further data bytes. The low 5 bits of the address advance after each byte and wrap inside the 32-byte page, while the upper address bits stay fixed.
- R6: Write data is stored only at the stop that ends the write. A repeated start after write data throws the buffered bytes away and starts no write cycle.
- R7: After a stop that stores data, the block does not acknowledge its device address word for WRITE_CYCLES system clocks. After that it acknowledges again.
- R8: A current-address read returns the byte at the internal address counter. After any read, the counter points one past the last byte sent.
- R9: A random read is a dummy write that loads the address, then a repeated start and a read address word. It returns the byte at the loaded address.
- R10: In a sequential read, each host acknowledge (0) after a data byte sends the byte at the next address. The address wraps from the last location to 0.
- R11: When the host does not acknowledge a read byte, the block releases the data line and ignores further clock pulses until a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| strap | input | 3 | Device select straps compared with address word bits 3:1 |
| sdaOe | output | 1 | When high, pulls the bus data line low |

## Verification
Two pairs of functions can collide. The first is the end of a write, where the stop both stores the page and starts the busy period. The bench issues an address poll right after such a stop. It expects no acknowledge at first, an acknowledge later, and the stored bytes when they are read back. The second is a page that wraps, so a sequential read crossing the page end and the array end must show both wraps. A repeated start after buffered write data must leave memory unchanged and must not make the block busy; an immediate poll that is acknowledged shows this.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef struct packed {
    logic sdaBit;
    logic shiftIn;
    logic loadAddrHi;
    logic loadAddrLo;
    logic bufWrite;
    logic clearBuf;
    logic commit;
    logic loadRead;
    logic shiftOut;
  } ee_strobe_t;
endpackage

// File: rtl/eeprom_dp.sv
module eeprom_dp
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_BYTES = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  ee_strobe_t strb,
  output logic [7:0] rxByte,
  output logic       txBit,
  output logic       bufAny
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PG_W = $clog2(PAGE_BYTES);

  logic [7:0] rxShift;
  logic [7:0] txShift;
  logic [ADDR_W-1:0] addrCnt;
  logic [ADDR_W-1:0] loadVal;
  logic [7:0] mem [DEPTH];
  logic [7:0] pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageVld;

  generate
    if (ADDR_W > 8) begin : g_twoByte
      logic [ADDR_W-9:0] addrHi;
      always_ff @(posedge clk) begin
        if (!rstN) addrHi <= '0;
        else if (strb.loadAddrHi) addrHi <= rxShift[ADDR_W-9:0];
      end
      assign loadVal = {addrHi, rxShift};
    end else begin : g_oneByte
      assign loadVal = rxShift[ADDR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      addrCnt <= '0;
      pageVld <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[6:0], strb.sdaBit};
      if (strb.loadAddrLo) addrCnt <= loadVal;
      if (strb.bufWrite) begin
        pageBuf[addrCnt[PG_W-1:0]] <= rxShift;
        pageVld[addrCnt[PG_W-1:0]] <= 1'b1;
        addrCnt <= {addrCnt[ADDR_W-1:PG_W], addrCnt[PG_W-1:0] + PG_W'(1)};
      end
      if (strb.loadRead) begin
        txShift <= mem[addrCnt];
        addrCnt <= addrCnt + ADDR_W'(1);
      end
      if (strb.shiftOut) txShift <= {txShift[6:0], 1'b0};
      if (strb.commit) begin
        for (int i = 0; i < PAGE_BYTES; i++)
          if (pageVld[i]) mem[{addrCnt[ADDR_W-1:PG_W], PG_W'(i)}] <= pageBuf[i];
        pageVld <= '0;
      end
      if (strb.clearBuf) pageVld <= '0;
    end
  end

  assign rxByte = rxShift;
  assign txBit = txShift[7];
  assign bufAny = |pageVld;

  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.bufWrite |=> addrCnt[ADDR_W-1:PG_W] == $past(addrCnt[ADDR_W-1:PG_W])); // R5
  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRead |=> addrCnt == $past(addrCnt) + ADDR_W'(1)); // R10
  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !bufAny); // R6
endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [3:0] DEV_CODE = 4'b1010,
  parameter int WRITE_CYCLES = 300
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  input  logic       bufAny,
  output ee_strobe_t strb,
  output logic       sdaOe
);
  localparam bit TWO_BYTE = ADDR_W > 8;
  localparam int BW = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_ACKDEV, S_ADRH, S_ACKH, S_ADRL, S_ACKL,
    S_WDAT, S_ACKW, S_RDAT, S_RACK, S_WAIT
  } st_t;

  st_t state;
  logic [2:0] sclS, sdaS;
  logic [3:0] bitCnt;
  logic rwReg, hostAck;
  logic [BW-1:0] busyCnt;
  logic busy;

  wire sclRise = sclS[1] & ~sclS[2];
  wire sclFall = ~sclS[1] & sclS[2];
  wire startDet = sclS[1] & sclS[2] & sdaS[2] & ~sdaS[1];
  wire stopDet = sclS[1] & sclS[2] & ~sdaS[2] & sdaS[1];
  wire rxState = (state == S_DEV) || (state == S_ADRH) || (state == S_ADRL) || (state == S_WDAT);
  wire byteEnd = sclFall && (bitCnt == 4'd8);
  wire devMatch = (rxByte[7:4] == DEV_CODE) && (rxByte[3:1] == strap);

  assign busy = busyCnt != '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclS <= '1;
      sdaS <= '1;
    end else begin
      sclS <= {sclS[1:0], scl};
      sdaS <= {sdaS[1:0], sdaIn};
    end
  end

  always_comb begin
    strb = '0;
    strb.sdaBit = sdaS[1];
    strb.shiftIn = sclRise && rxState;
    strb.clearBuf = startDet;
    strb.commit = stopDet && bufAny;
    if (byteEnd && !startDet && !stopDet) begin
      strb.loadAddrHi = state == S_ADRH;
      strb.loadAddrLo = state == S_ADRL;
      strb.bufWrite = state == S_WDAT;
    end
    if (sclFall && !startDet && !stopDet) begin
      strb.loadRead = ((state == S_ACKDEV) && rwReg) || ((state == S_RACK) && hostAck);
      strb.shiftOut = (state == S_RDAT) && (bitCnt != 4'd8);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      bitCnt <= '0;
      rwReg <= 1'b0;
      hostAck <= 1'b0;
      busyCnt <= '0;
    end else begin
      if (strb.commit) busyCnt <= BW'(WRITE_CYCLES);
      else if (busy) busyCnt <= busyCnt - BW'(1);
      if (startDet) begin
        state <= S_DEV;
        bitCnt <= '0;
      end else if (stopDet) begin
        state <= S_IDLE;
        bitCnt <= '0;
      end else begin
        if (sclRise && (rxState || state == S_RDAT)) bitCnt <= bitCnt + 4'd1;
        if (sclRise && state == S_RACK) hostAck <= ~sdaS[1];
        if (sclFall) begin
          case (state)
            S_DEV: if (bitCnt == 4'd8) begin
              bitCnt <= '0;
              rwReg <= rxByte[0];
              state <= (devMatch && !busy) ? S_ACKDEV : S_WAIT;
            end
            S_ACKDEV: state <= rwReg ? S_RDAT : (TWO_BYTE ? S_ADRH : S_ADRL);
            S_ADRH: if (bitCnt == 4'd8) begin bitCnt <= '0; state <= S_ACKH; end
            S_ACKH: state <= S_ADRL;
            S_ADRL: if (bitCnt == 4'd8) begin bitCnt <= '0; state <= S_ACKL; end
            S_ACKL: state <= S_WDAT;
            S_WDAT: if (bitCnt == 4'd8) begin bitCnt <= '0; state <= S_ACKW; end
            S_ACKW: state <= S_WDAT;
            S_RDAT: if (bitCnt == 4'd8) begin bitCnt <= '0; state <= S_RACK; end
            S_RACK: state <= hostAck ? S_RDAT : S_WAIT;
            default: ;
          endcase
        end
      end
    end
  end

  assign sdaOe = (state == S_ACKDEV) || (state == S_ACKH) || (state == S_ACKL) ||
                 (state == S_ACKW) || ((state == S_RDAT) && !txBit);

  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> state != S_ACKDEV); // R7
  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> busy); // R7
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS[1]); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftIn, strb.loadAddrHi, strb.loadAddrLo, strb.bufWrite,
              strb.clearBuf, strb.commit, strb.loadRead, strb.shiftOut})); // R1
  AST_RELEASE_AFTER_NACK: assert property (@(posedge clk) disable iff (!rstN)
    state == S_WAIT |-> !sdaOe); // R11
endmodule

// File: rtl/eeprom_target.sv
module eeprom_target
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_BYTES = 32,
  parameter int WRITE_CYCLES = 300,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  output logic       sdaOe
);
  ee_strobe_t strb;
  logic [7:0] rxByte;
  logic txBit, bufAny;

  eeprom_ctrl #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE), .WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn), .strap(strap),
    .rxByte(rxByte), .txBit(txBit), .bufAny(bufAny), .strb(strb), .sdaOe(sdaOe));

  eeprom_dp #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte), .txBit(txBit), .bufAny(bufAny));
endmodule

// File: tb/eeprom_target_tb.sv
module eeprom_target_tb;
  localparam int Q = 5;
  localparam logic [7:0] DEVW = 8'hAA;
  localparam logic [7:0] DEVR = 8'hAB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic hostSda = 1'b1;
  logic sdaOe;
  wire sdaLine = hostSda & ~sdaOe;
  logic [2:0] strap = 3'b101;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t expQ[$];
  logic [7:0] obsByte;
  event byteDone;

  eeprom_target #(.WRITE_CYCLES(300)) u_dut (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaLine), .strap(strap), .sdaOe(sdaOe));

  always #10 clk = ~clk;

  task automatic q(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_byte(logic [7:0] v, string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  initial begin
    forever begin
      @(byteDone);
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL scoreboard: actual %h expected none", obsByte);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(obsByte, e.v, e.tag);
      end
    end
  end

  task automatic startCond();
    hostSda = 1'b1; q(Q);
    scl = 1'b1; q(Q);
    hostSda = 1'b0; q(Q);
    scl = 1'b0; q(Q);
  endtask

  task automatic stopCond();
    hostSda = 1'b0; q(Q);
    scl = 1'b1; q(Q);
    hostSda = 1'b1; q(2 * Q);
  endtask

  task automatic sendBits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      q(Q); hostSda = b[i]; q(Q);
      scl = 1'b1; q(2 * Q);
      scl = 0;
    end
  endtask

  task automatic sendByte(logic [7:0] b, output logic ack);
    sendBits(b, 8);
    q(Q); hostSda = 1'b1; q(Q);
    scl = 1'b1; q(Q);
    ack = ~sdaLine; q(Q);
    scl = 1'b0;
  endtask

  task automatic sendChk(logic [7:0] b, logic expAck, string tag);
    logic a;
    sendByte(b, a);
    check({7'd0, a}, {7'd0, expAck}, tag);
  endtask

  task automatic readByte(logic ack);
    logic [7:0] b;
    hostSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(2 * Q); scl = 1'b1; q(Q);
      b[i] = sdaLine; q(Q);
      scl = 1'b0;
    end
    obsByte = b;
    ->byteDone;
    q(Q); hostSda = ~ack; q(Q);
    scl = 1'b1; q(2 * Q);
    scl = 1'b0; q(Q);
    hostSda = 1'b1;
  endtask

  task automatic readSeq(int n);
    for (int i = 0; i < n; i++) readByte(i != n - 1);
  endtask

  task automatic pollReady(output int polls);
    logic a;
    polls = 0;
    a = 1'b0;
    while (!a && polls < 40) begin
      startCond();
      sendByte(DEVW, a);
      stopCond();
      polls++;
    end
  endtask

  task automatic byteWrite(logic [7:0] addr, logic [7:0] d);
    startCond();
    sendChk(DEVW, 1'b1, "R2 write word ack");
    sendChk(addr, 1'b1, "R3 address ack");
    sendChk(d, 1'b1, "R4 data ack");
    stopCond();
  endtask

  task automatic randomRead(logic [7:0] addr);
    startCond();
    sendChk(DEVW, 1'b1, "R9 dummy write ack");
    sendChk(addr, 1'b1, "R9 address ack");
    startCond();
    sendChk(DEVR, 1'b1, "R9 read word ack");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int polls;
    q(4);
    rstN = 1'b1;
    q(4);
    check({7'd0, sdaOe}, 8'd0, "R3 released after reset");

    // R4 / R7: byte write then busy polling
    byteWrite(8'h10, 8'hA5);
    pollReady(polls);
    check({7'd0, polls > 1}, 8'd1, "R7 first poll refused");
    check({7'd0, polls < 40}, 8'd1, "R7 ack returns after write cycle");

    // R9 random read, R8 current address read after it
    randomRead(8'h10);
    expect_byte(8'hA5, "R4 byte stored, R9 random read");
    readSeq(1);
    stopCond();
    byteWrite(8'h11, 8'h5A);
    pollReady(polls);
    randomRead(8'h10);
    expect_byte(8'hA5, "R9 reread");
    readSeq(1);
    stopCond();
    startCond();
    sendChk(DEVR, 1'b1, "R8 current read word ack");
    expect_byte(8'h5A, "R8 counter one past last byte sent");
    readSeq(1);
    stopCond();

    // R2 mismatches
    startCond();
    sendChk(8'hA8, 1'b0, "R2 wrong strap no ack");
    stopCond();
    startCond();
    sendChk(8'hBA, 1'b0, "R2 wrong device code no ack");
    stopCond();

    // R5 page write with wrap inside the page
    startCond();
    sendChk(DEVW, 1'b1, "R5 word ack");
    sendChk(8'h3C, 1'b1, "R5 address ack");
    for (int i = 0; i < 6; i++) sendChk(8'hC0 + 8'(i), 1'b1, "R5 page data ack");
    stopCond();
    pollReady(polls);
    check({7'd0, polls > 1}, 8'd1, "R7 busy after page write");
    randomRead(8'h3C);
    expect_byte(8'hC0, "R5 page byte 0");
    expect_byte(8'hC1, "R5 page byte 1");
    expect_byte(8'hC2, "R5 page byte 2");
    expect_byte(8'hC3, "R5 page byte 3");
    expect_byte(8'h00, "R5 next page untouched");
    readSeq(5);
    stopCond();
    randomRead(8'h20);
    expect_byte(8'hC4, "R5 wrapped byte at page start");
    expect_byte(8'hC5, "R5 wrapped byte 2");
    readSeq(2);
    stopCond();
    startCond();
    sendChk(DEVR, 1'b1, "R8 current read ack");
    expect_byte(8'h00, "R8 current address after sequential read");
    readSeq(1);
    stopCond();

    // R6 repeated start discards buffered data, no busy
    startCond();
    sendChk(DEVW, 1'b1, "R6 word ack");
    sendChk(8'h50, 1'b1, "R6 address ack");
    sendChk(8'h77, 1'b1, "R6 data ack");
    startCond();
    sendChk(DEVW, 1'b1, "R6 no write cycle after repeated start");
    stopCond();
    randomRead(8'h50);
    expect_byte(8'h00, "R6 discarded data not stored");
    readSeq(1);
    stopCond();

    // R1 start in the middle of a data byte
    startCond();
    sendChk(DEVW, 1'b1, "R1 word ack");
    sendChk(8'h60, 1'b1, "R1 address ack");
    sendBits(8'hFF, 3);
    startCond();
    sendChk(DEVW, 1'b1, "R1 restart accepted mid byte");
    stopCond();
    randomRead(8'h60);
    expect_byte(8'h00, "R1 aborted byte not stored");
    readSeq(1);
    stopCond();

    // R10 sequential read across the array end
    byteWrite(8'hFF, 8'h12);
    pollReady(polls);
    byteWrite(8'h00, 8'h34);
    pollReady(polls);
    randomRead(8'hFF);
    expect_byte(8'h12, "R10 last location");
    expect_byte(8'h34, "R10 wrap to zero");
    readSeq(2);

    // R11 after host no-ack, line stays released during more clocks
    begin
      int low = 0;
      for (int i = 0; i < 9; i++) begin
        q(Q); scl = 1'b1; q(Q);
        if (!sdaLine) low++;
        q(Q); scl = 1'b0;
      end
      check(8'(low), 8'd0, "R11 released after host no-ack");
    end
    stopCond();
    check({7'd0, sdaOe}, 8'd0, "R3 released when idle");

    q(20);
    check(8'(expQ.size()), 8'd0, "scoreboard drained");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule